// File: doc/BRIEF.md
# Repeating Bit-Pattern Test Generator

This block produces a repeating serial test pattern for exercising a signal path and measuring how that path distorts pulses. A pattern is a frame of sixteen slots. Each slot lasts half a clock cycle. The block hands two slots per clock cycle to a double-data-rate output stage, so one frame takes eight cycles. Frames follow each other with no gap.

A 4-bit select input picks one of twelve built-in frames:
- square waves whose runs are 1, 2, 4 or 8 slots long;
- a single high pulse, 1 to 4 slots wide, on a low background;
- a single low pulse, 1 to 4 slots wide, on a high background.

A frame-start strobe marks the cycle that carries slot 0. A capture circuit clocked from the same source can use it to align its sampling points, which allows equivalent-time sampling over many frames.

The physical double-data-rate primitive is not part of the block. It is represented by a 2-bit output port: bit 0 goes out on the rising edge and bit 1 on the falling edge.

Top module: `ddr_pattern_gen`

## Requirements
- R1: While `rst` is high and at least one rising clock edge has passed, `ddr_out` is 2'b00 and `frame_start` is 0. The first cycle after `rst` falls carries slots 0 and 1 of the selected frame, with `frame_start` high.
- R2: `frame_start` is high in exactly one cycle out of every eight, and never in two cycles in a row.
- R3: In the k-th cycle of a frame (k = 0..7, where k = 0 is the `frame_start` cycle), `ddr_out[0]` carries slot 2k and `ddr_out[1]` carries slot 2k+1.
- R4: Select values 0, 1, 2 and 3 give square waves with runs of 1, 2, 4 and 8 slots. Each starts high at slot 0. Written as a word with slot i at bit i, they are 16'h5555, 16'h3333, 16'h0F0F and 16'h00FF.
- R5: Select values 4, 5, 6 and 7 give a high pulse that is 1, 2, 3 or 4 slots wide, starting at slot 0, with all other slots low: 16'h0001, 16'h0003, 16'h0007, 16'h000F.
- R6: Select values 8, 9, 10 and 11 give a low pulse that is 1, 2, 3 or 4 slots wide, starting at slot 0, with all other slots high: 16'hFFFE, 16'hFFFC, 16'hFFF8, 16'hFFF0.
- R7: Select values 12 to 15 give a frame in which every slot is low.
- R8: The block samples `pat_sel` on the rising edge that ends the last cycle of a frame. A change in the middle of a frame leaves the rest of that frame unchanged and takes effect from the next slot 0.
- R9: While the select is held, the same frame repeats with no idle cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; two slots are emitted per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 4 | Frame select, values 0 to 15 |
| ddr_out | output | 2 | Bit 0 is the rising-edge slot, bit 1 is the falling-edge slot |
| frame_start | output | 1 | High in the cycle that carries slots 0 and 1 |

## Verification
The bench reads each select value back as a whole 16-slot word. A design that swapped the even and odd lanes would return pulses mirrored within each pair. A design whose run lengths or pulse widths were off by one would return a word that does not match the stated hex value.

The bench changes the select in the middle of a frame. A design that acted on the change at once would emit a torn frame that mixes the old and new patterns.

The bench checks that consecutive frames join with `frame_start` exactly eight cycles apart. A counter that wrapped at the wrong count would show a gap or an overlap between frames.

The bench also checks the state during reset, both at start-up and in the middle of a run, and the first cycle after reset is released. A design that started one cycle late would lose the strobe in that cycle.

// File: rtl/ddr_tpg_pkg.sv
package ddr_tpg_pkg;

    localparam int SLOTS  = 16;
    localparam int LANES  = 2;
    localparam int CYCLES = SLOTS / LANES;
    localparam int PH_W   = $clog2(CYCLES);
    localparam int SEL_W  = 4;

    typedef logic [SLOTS-1:0] frame_word_t;
    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        FAM_SQUARE     = 2'd0,
        FAM_HIGH_PULSE = 2'd1,
        FAM_LOW_PULSE  = 2'd2,
        FAM_OFF        = 2'd3
    } family_e;

    typedef struct packed {
        logic odd;
        logic even;
    } slot_pair_t;

    // Slot i of the frame is bit i of the returned word.
    function automatic frame_word_t build_word(sel_t sel);
        frame_word_t w;
        family_e     fam;
        int          idx;
        fam = family_e'(sel[SEL_W-1:SEL_W-2]);
        idx = int'(sel[1:0]);
        w   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            case (fam)
                FAM_SQUARE:     w[i] = (((i >> idx) & 1) == 0);
                FAM_HIGH_PULSE: w[i] = (i <= idx);
                FAM_LOW_PULSE:  w[i] = (i > idx);
                default:        w[i] = 1'b0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/tpg_pattern_rom.sv
module tpg_pattern_rom
    import ddr_tpg_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [SLOTS-1:0] word
);
    always_comb word = build_word(sel);
endmodule

// File: rtl/tpg_phase_ctr.sv
module tpg_phase_ctr
    import ddr_tpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last_cycle
);
    localparam phase_t LAST = phase_t'(CYCLES - 1);

    phase_t ph_q;

    // Reset parks on the last cycle so the first edge after release loads a frame.
    always_ff @(posedge clk) begin
        if (rst)               ph_q <= LAST;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + phase_t'(1);
    end

    assign phase      = ph_q;
    assign last_cycle = (ph_q == LAST);
endmodule

// File: rtl/tpg_slot_mux.sv
module tpg_slot_mux
    import ddr_tpg_pkg::*;
(
    input  logic [SLOTS-1:0] word,
    input  logic [PH_W-1:0]  phase,
    output logic [LANES-1:0] lanes
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb lanes[l] = word[int'(phase) * LANES + l];
    end
endmodule

// File: rtl/ddr_pattern_gen.sv
module ddr_pattern_gen
    import ddr_tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] pat_sel,
    output logic [1:0] ddr_out,
    output logic       frame_start
);
    frame_word_t next_word;
    frame_word_t cur_word;
    phase_t      phase;
    logic        last_cycle;
    logic [LANES-1:0] lanes;
    slot_pair_t  pair;

    tpg_pattern_rom u_rom (
        .sel  (pat_sel),
        .word (next_word)
    );

    tpg_phase_ctr u_phase (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .last_cycle (last_cycle)
    );

    // The frame word is latched only at a frame boundary.
    always_ff @(posedge clk) begin
        if (rst)             cur_word <= '0;
        else if (last_cycle) cur_word <= next_word;
    end

    tpg_slot_mux u_mux (
        .word  (cur_word),
        .phase (phase),
        .lanes (lanes)
    );

    assign pair        = slot_pair_t'(lanes);
    assign ddr_out     = {pair.odd, pair.even};
    assign frame_start = (phase == '0);
endmodule

// File: rtl/ddr_pattern_gen_chk.sv
module ddr_pattern_gen_chk
    import ddr_tpg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] pat_sel,
    input logic [1:0] ddr_out,
    input logic       frame_start
);
    logic   rst_seen;
    logic   fs_seen;
    phase_t gap;

    always_ff @(posedge clk) rst_seen <= rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_seen <= 1'b0;
            gap     <= '0;
        end else if (frame_start) begin
            fs_seen <= 1'b1;
            gap     <= '0;
        end else begin
            gap     <= gap + phase_t'(1);
        end
    end

    always @(negedge clk) begin
        if (rst_seen === 1'b1 && rst === 1'b1)
            AST_RESET_QUIET: assert (ddr_out == 2'b00 && frame_start == 1'b0); // R1
    end

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R2

    AST_FS_SPACING: assert property (@(posedge clk) disable iff (rst)
        (frame_start && fs_seen) |-> (gap == phase_t'(CYCLES - 1))); // R2

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (frame_start && $past(pat_sel) >= 4'd12) |-> (ddr_out == 2'b00)); // R7

    AST_SLOT0_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (frame_start && $past(pat_sel) < 4'd12) |-> (ddr_out[0] == ($past(pat_sel) < 4'd8))); // R4 R5 R6
endmodule

bind ddr_pattern_gen ddr_pattern_gen_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .pat_sel     (pat_sel),
    .ddr_out     (ddr_out),
    .frame_start (frame_start)
);

// File: tb/test_ddr_pattern_gen.sv
module test_ddr_pattern_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pat_sel = 4'd0;
    logic [1:0] ddr_out;
    logic       frame_start;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ddr_pattern_gen i_ddr_pattern_gen (
        .clk         (clk),
        .rst         (rst),
        .pat_sel     (pat_sel),
        .ddr_out     (ddr_out),
        .frame_start (frame_start)
    );

    // {select, expected frame word with slot i at bit i}
    localparam logic [19:0] VEC [16] = '{
        {4'd0,  16'h5555}, {4'd1,  16'h3333}, {4'd2,  16'h0F0F}, {4'd3,  16'h00FF},
        {4'd4,  16'h0001}, {4'd5,  16'h0003}, {4'd6,  16'h0007}, {4'd7,  16'h000F},
        {4'd8,  16'hFFFE}, {4'd9,  16'hFFFC}, {4'd10, 16'hFFF8}, {4'd11, 16'hFFF0},
        {4'd12, 16'h0000}, {4'd13, 16'h0000}, {4'd14, 16'h0000}, {4'd15, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (frame_start !== 1'b1);
    endtask

    // Called at the negedge of a frame_start cycle; collects eight cycles.
    task automatic grab(output logic [15:0] w, output int fs_count);
        fs_count = 0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            w[2*k]     = ddr_out[0];
            w[2*k + 1] = ddr_out[1];
            if (frame_start === 1'b1) fs_count++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [15:0] w2;
        int fsc;
        string req;

        // R1: reset state and first cycle after release
        repeat (3) @(negedge clk);
        check(ddr_out == 2'b00 && frame_start == 1'b0, "R1", "reset idle",
              {13'd0, frame_start, ddr_out}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check(frame_start == 1'b1 && ddr_out == 2'b01, "R1", "first cycle after reset",
              {13'd0, frame_start, ddr_out}, 16'h5);

        // R3 R4 R5 R6 R7: every select value read back as a word
        foreach (VEC[n]) begin
            @(negedge clk);
            pat_sel = VEC[n][19:16];
            wait_frame();
            grab(w, fsc);
            if (n < 4)       req = "R3/R4";
            else if (n < 8)  req = "R3/R5";
            else if (n < 12) req = "R3/R6";
            else             req = "R7";
            check(w == VEC[n][15:0], req, $sformatf("sel=%0d word", n), w, VEC[n][15:0]);
            check(fsc == 1, "R2", $sformatf("sel=%0d strobe count", n), 16'(fsc), 16'd1);
        end

        // R9: back-to-back frames with no gap
        @(negedge clk);
        pat_sel = 4'd5;
        wait_frame();
        grab(w, fsc);
        @(negedge clk);
        check(frame_start == 1'b1, "R9", "next frame starts at once",
              {15'd0, frame_start}, 16'd1);
        grab(w2, fsc);
        check(w == 16'h0003 && w2 == 16'h0003, "R9", "repeated frame", w2, 16'h0003);

        // R8: mid-frame select change waits for the boundary
        @(negedge clk);
        pat_sel = 4'd3;
        wait_frame();
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 3) pat_sel = 4'd8;
            w[2*k]     = ddr_out[0];
            w[2*k + 1] = ddr_out[1];
        end
        check(w == 16'h00FF, "R8", "frame not torn by change", w, 16'h00FF);
        @(negedge clk);
        grab(w2, fsc);
        check(w2 == 16'hFFFE, "R8", "new select at next frame", w2, 16'hFFFE);

        // R1: reset in the middle of a run
        @(negedge clk);
        pat_sel = 4'd11;
        wait_frame();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ddr_out == 2'b00 && frame_start == 1'b0, "R1", "mid-run reset",
              {13'd0, frame_start, ddr_out}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check(frame_start == 1'b1 && ddr_out == 2'b00, "R1", "restart after mid-run reset",
              {13'd0, frame_start, ddr_out}, 16'h4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule